// File: doc/BRIEF.md
# Programmable RGB to YCbCr Matrix Converter

The block converts a stream of 10-bit RGB pixels into 10-bit YCbCr, one pixel per cycle. Each component first receives a signed 12-bit pre-offset; the three biased components are multiplied by a 3x3 matrix of signed 13-bit coefficients, in which 1024 stands for a gain of 1.0. Each row sum is rounded to nearest, scaled down by 10 bits, shifted right by a programmable amount, and given a signed 12-bit post-offset. The result is clamped to 0..1023. A control bit selects between conversion and unmodified pass-through.

Software loads the coefficients and offsets through a simple 32-bit write port, two values per word. Writes go into a staging copy, and a frame-start pulse moves the staging copy into the working copy, so a frame is never processed with a mix of old and new settings. The pixel path is a valid/ready stream through a fixed three-stage pipeline that stalls as a whole under backpressure.

Top module: `csc_matrix`

## Requirements
- R1: After reset, out_valid_o is low and in_ready_o is high, and the working settings are: enable clear, pre-offsets 0, shift 0, post-offsets 64 (row 0) and 512 (rows 1 and 2), and coefficients c00..c22 equal to 186, 627, 63, -102, -344, 448, 448, -406, -40.
- R2: Register word layout (address: fields): 0: enable at bit 0. 1: pre-offset 0 at 27:16, pre-offset 1 at 11:0. 2: pre-offset 2 at 11:0. 3, 4, 5, 6: coefficient pairs (c00,c01), (c02,c10), (c11,c12), (c20,c21), first of the pair at 28:16, second at 12:0. 7: c22 at 12:0, right shift at 18:16; bits 31:30 (mode) are ignored. 8: post-offset 0 at 27:16, post-offset 1 at 11:0. 9: post-offset 2 at 11:0. Writes to addresses 10..15 have no effect.
- R3: A register write changes only the staging copy; the working copy takes all staged values in the clock edge where frame_start_i is high, and stays unchanged otherwise.
- R4: With enable clear, each output pixel equals its input pixel bit for bit.
- R5: Pixels carry component 0 (R in, Y out) at bits 9:0, component 1 (G, Cb) at 19:10, component 2 (B, Cr) at 29:20. With enable set, output row i is ((sum over j of c_ij*(x_j+pre_j)) + 512) >>> 10, then >>> shift, then + post_i.
- R6: Each output component saturates to 0 when the result is negative and to 1023 when it exceeds 1023.
- R7: With out_ready_i high, a pixel accepted at clock edge k appears on out_pix_o with out_valid_o high after edge k+2; at most three pixels are inside the block at once.
- R8: While out_valid_o is high and out_ready_i low, in_ready_o is low and out_pix_o holds; every accepted pixel leaves exactly once, in order.
- R9: Pre-offsets are signed two's-complement values and may drive the biased input below zero.
- R10: The right shift is applied arithmetically after the rounding step and before the post-offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register word address |
| wr_data_i | input | 32 | Register write data |
| frame_start_i | input | 1 | Pulse that moves staged settings into the working copy |
| in_valid_i | input | 1 | Input pixel valid |
| in_ready_o | output | 1 | Block can take an input pixel |
| in_pix_i | input | 30 | Input RGB pixel |
| out_valid_o | output | 1 | Output pixel valid |
| out_ready_i | input | 1 | Downstream can take the output pixel |
| out_pix_o | output | 30 | Output YCbCr pixel |

## Verification
A pixel accepted at one edge is due on the output after the second following edge when not stalled, a staged write is due in the working copy after the edge of the frame-start pulse, and an enable change is seen only by pixels accepted after that pulse. The bench drives all inputs just after a rising edge and samples just before the next, queuing each expected pixel when it is offered and comparing in order whenever a transfer is visible, so the stall pattern never shifts an expected value. Latency is counted explicitly in falling edges from the accepting edge, and settings are changed only with the pipeline drained.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int unsigned CSC_DW    = 10;  // component width
  localparam int unsigned CSC_CW    = 13;  // coefficient width
  localparam int unsigned CSC_OW    = 12;  // offset width
  localparam int unsigned CSC_SHW   = 3;   // right-shift field width
  localparam int unsigned CSC_FRAC  = 10;  // coefficient fraction bits
  localparam int unsigned CSC_AW    = 4;
  localparam int unsigned CSC_NC    = 3;
  localparam int unsigned CSC_NCOEF = CSC_NC * CSC_NC;
  localparam int unsigned CSC_NPAIR = (CSC_NCOEF - 1) / 2;

  localparam int unsigned A_CTRL   = 0;
  localparam int unsigned A_PRE01  = 1;
  localparam int unsigned A_PRE2   = 2;
  localparam int unsigned A_COEF0  = 3;
  localparam int unsigned A_LAST   = A_COEF0 + CSC_NPAIR;
  localparam int unsigned A_POST01 = A_LAST + 1;
  localparam int unsigned A_POST2  = A_LAST + 2;

  typedef struct packed {
    logic                                en;
    logic [CSC_NC-1:0][CSC_OW-1:0]       pre;
    logic [CSC_NCOEF-1:0][CSC_CW-1:0]    coef;
    logic [CSC_SHW-1:0]                  shift;
    logic [CSC_NC-1:0][CSC_OW-1:0]       post;
  } csc_cfg_t;

  // limited-range BT.709 defaults, index 0 = c00
  localparam csc_cfg_t CSC_CFG_RST = '{
    en:    1'b0,
    pre:   '0,
    coef:  {13'h1FD8, 13'h1E6A, 13'h01C0,
            13'h01C0, 13'h1EA8, 13'h1F9A,
            13'h003F, 13'h0273, 13'h00BA},
    shift: '0,
    post:  {12'h200, 12'h200, 12'h040}
  };
endpackage

// File: rtl/csc_regfile.sv
module csc_regfile
  import csc_pkg::*;
#(
  parameter int unsigned AW = CSC_AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [31:0]   wr_data_i,
  input  logic          frame_start_i,
  output csc_cfg_t      cfg_o
);
  csc_cfg_t pend_q, act_q;
  logic unused_bits;
  assign unused_bits = ^{wr_data_i[31:29], wr_data_i[15:13]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= CSC_CFG_RST;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        AW'(A_CTRL):   pend_q.en <= wr_data_i[0];
        AW'(A_PRE01):  begin
          pend_q.pre[0] <= wr_data_i[16 +: CSC_OW];
          pend_q.pre[1] <= wr_data_i[0 +: CSC_OW];
        end
        AW'(A_PRE2):   pend_q.pre[2] <= wr_data_i[0 +: CSC_OW];
        AW'(A_LAST):   begin
          pend_q.coef[CSC_NCOEF-1] <= wr_data_i[0 +: CSC_CW];
          pend_q.shift             <= wr_data_i[16 +: CSC_SHW];
        end
        AW'(A_POST01): begin
          pend_q.post[0] <= wr_data_i[16 +: CSC_OW];
          pend_q.post[1] <= wr_data_i[0 +: CSC_OW];
        end
        AW'(A_POST2):  pend_q.post[2] <= wr_data_i[0 +: CSC_OW];
        default: begin
          for (int k = 0; k < CSC_NPAIR; k++) begin
            if (wr_addr_i == AW'(A_COEF0 + k)) begin
              pend_q.coef[2*k]   <= wr_data_i[16 +: CSC_CW];
              pend_q.coef[2*k+1] <= wr_data_i[0 +: CSC_CW];
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            act_q <= CSC_CFG_RST;
    else if (frame_start_i) act_q <= pend_q;
  end

  assign cfg_o = act_q;
endmodule

// File: rtl/csc_datapath.sv
module csc_datapath
  import csc_pkg::*;
#(
  parameter int unsigned DW   = CSC_DW,
  parameter int unsigned CW   = CSC_CW,
  parameter int unsigned OW   = CSC_OW,
  parameter int unsigned FRAC = CSC_FRAC,
  parameter int unsigned NC   = CSC_NC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  csc_cfg_t         cfg_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [NC*DW-1:0] in_pix_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [NC*DW-1:0] out_pix_o
);
  localparam int unsigned XW   = OW + 1;
  localparam int unsigned PW   = XW + CW;
  localparam int unsigned SW   = PW + 2;
  localparam int unsigned PIXW = NC * DW;
  localparam logic signed [SW-1:0] RND  = SW'(2 ** (FRAC - 1));
  localparam logic signed [SW-1:0] MAXV = SW'(2 ** DW - 1);

  logic adv;
  logic v1_q, v2_q, v3_q;
  logic en1_q, en2_q;
  logic [PIXW-1:0] raw1_q, raw2_q, pix_q, y_cat;
  logic signed [XW-1:0] x1_q [NC];
  logic signed [PW-1:0] p2_q [NC][NC];

  // whole pipe advances together; a stalled output freezes every stage
  assign adv        = !v3_q || out_ready_i;
  assign in_ready_o = adv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      v3_q <= 1'b0;
    end else if (adv) begin
      v1_q <= in_valid_i;
      v2_q <= v1_q;
      v3_q <= v2_q;
    end
  end

  always_ff @(posedge clk_i) begin
    if (adv) begin
      en1_q  <= cfg_i.en;
      en2_q  <= en1_q;
      raw1_q <= in_pix_i;
      raw2_q <= raw1_q;
      for (int j = 0; j < NC; j++) begin
        x1_q[j] <= $signed({{(XW-DW){1'b0}}, in_pix_i[j*DW +: DW]})
                 + $signed({cfg_i.pre[j][OW-1], cfg_i.pre[j]});
      end
      for (int i = 0; i < NC; i++) begin
        for (int j = 0; j < NC; j++) begin
          p2_q[i][j] <= PW'(x1_q[j]) * PW'($signed(cfg_i.coef[i*NC+j]));
        end
      end
      pix_q <= en2_q ? y_cat : raw2_q;
    end
  end

  for (genvar gi = 0; gi < NC; gi++) begin : g_row
    logic signed [SW-1:0] acc, shd, res;
    logic [DW-1:0] y;
    always_comb begin
      acc = RND;
      for (int j = 0; j < NC; j++) acc = acc + SW'(p2_q[gi][j]);
      shd = (acc >>> FRAC) >>> cfg_i.shift;
      res = shd + SW'($signed(cfg_i.post[gi]));
      if (res < 0)         y = '0;
      else if (res > MAXV) y = '1;
      else                 y = res[DW-1:0];
    end
    assign y_cat[gi*DW +: DW] = y;
  end

  assign out_valid_o = v3_q;
  assign out_pix_o   = pix_q;
endmodule

// File: rtl/csc_matrix.sv
module csc_matrix
  import csc_pkg::*;
#(
  parameter int unsigned ADDR_W = CSC_AW,
  parameter int unsigned PIX_W  = CSC_NC * CSC_DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic              frame_start_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [PIX_W-1:0]  in_pix_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [PIX_W-1:0]  out_pix_o
);
  csc_cfg_t cfg_q;

  csc_regfile #(.AW(ADDR_W)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en_i),
    .wr_addr_i     (wr_addr_i),
    .wr_data_i     (wr_data_i),
    .frame_start_i (frame_start_i),
    .cfg_o         (cfg_q)
  );

  csc_datapath u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_i       (cfg_q),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .in_pix_i    (in_pix_i),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_pix_o   (out_pix_o)
  );
endmodule

// File: rtl/csc_matrix_chk.sv
module csc_matrix_chk
  import csc_pkg::*;
#(
  parameter int unsigned PIX_W = CSC_NC * CSC_DW
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frame_start_i,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [PIX_W-1:0] out_pix_o,
  input csc_cfg_t         cfg_q
);
  logic [3:0] inflight_q;
  logic acc_in, acc_out;
  assign acc_in  = in_valid_i && in_ready_o;
  assign acc_out = out_valid_o && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inflight_q <= '0;
    else         inflight_q <= inflight_q + 4'(acc_in) - 4'(acc_out);
  end

  p_stall_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_pix_o));

  p_stall_block_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);

  p_inflight_max_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight_q <= 4'd3);

  p_empty_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight_q == 4'd0 |-> !out_valid_o);

  p_cfg_frame_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(cfg_q));
endmodule

bind csc_matrix csc_matrix_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .frame_start_i (frame_start_i),
  .in_valid_i    (in_valid_i),
  .in_ready_o    (in_ready_o),
  .out_valid_o   (out_valid_o),
  .out_ready_i   (out_ready_i),
  .out_pix_o     (out_pix_o),
  .cfg_q         (cfg_q)
);

// File: tb/csc_matrix_bench.sv
module csc_matrix_bench;
  localparam int DW   = 10;
  localparam int PIXW = 3 * DW;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 1'b0, frame_start_i = 1'b0;
  logic in_valid_i = 1'b0, out_ready_i = 1'b0;
  logic [3:0] wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [PIXW-1:0] in_pix_i = '0;
  logic in_ready_o, out_valid_o;
  logic [PIXW-1:0] out_pix_o;

  always #4 clk_i = ~clk_i;

  csc_matrix u_csc_matrix (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .frame_start_i(frame_start_i),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_pix_i(in_pix_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_pix_o(out_pix_o)
  );

  int n_chk = 0, n_fail = 0;
  int unsigned cyc = 0;
  bit done = 1'b0;
  logic [31:0] m_pend [10];
  logic [31:0] m_act  [10];
  logic [PIXW-1:0] exp_q [$];
  string tag_q [$];

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pk13(int a, int b);
    return {3'b0, a[12:0], 3'b0, b[12:0]};
  endfunction
  function automatic logic [31:0] pk12(int a, int b);
    return {4'b0, a[11:0], 4'b0, b[11:0]};
  endfunction
  function automatic int sx(logic [31:0] v, int w);
    int m;
    m = int'(v & ((32'd1 << w) - 1));
    return (m >= (1 << (w - 1))) ? m - (1 << w) : m;
  endfunction

  // expected output from R1, R2, R4, R5, R6, R9, R10
  function automatic logic [PIXW-1:0] model(logic [PIXW-1:0] px);
    int pre [3], post [3], c [9];
    int acc, r, sh;
    logic [PIXW-1:0] res;
    if (!m_act[0][0]) return px;
    pre[0] = sx(m_act[1] >> 16, 12); pre[1] = sx(m_act[1], 12); pre[2] = sx(m_act[2], 12);
    post[0] = sx(m_act[8] >> 16, 12); post[1] = sx(m_act[8], 12); post[2] = sx(m_act[9], 12);
    for (int k = 0; k < 8; k++)
      c[k] = (k % 2 == 0) ? sx(m_act[3 + k/2] >> 16, 13) : sx(m_act[3 + k/2], 13);
    c[8] = sx(m_act[7], 13);
    sh = int'((m_act[7] >> 16) & 32'd7);
    for (int i = 0; i < 3; i++) begin
      acc = 0;
      for (int j = 0; j < 3; j++) acc += c[i*3+j] * (int'(px[j*DW +: DW]) + pre[j]);
      r = ((acc + 512) >>> 10) >>> sh;
      r = r + post[i];
      if (r < 0) r = 0;
      if (r > 1023) r = 1023;
      res[i*DW +: DW] = r[9:0];
    end
    return res;
  endfunction

  function automatic logic [PIXW-1:0] rgb(int r, int g, int b);
    return {b[9:0], g[9:0], r[9:0]};
  endfunction

  task automatic init_model();
    m_pend[0] = 0; m_pend[1] = 0; m_pend[2] = 0;
    m_pend[3] = pk13(186, 627);  m_pend[4] = pk13(63, -102);
    m_pend[5] = pk13(-344, 448); m_pend[6] = pk13(448, -406);
    m_pend[7] = pk13(0, -40);    m_pend[8] = pk12(64, 512);
    m_pend[9] = pk12(0, 512);
    for (int k = 0; k < 10; k++) m_act[k] = m_pend[k];
  endtask

  // all driving tasks start and end just after a rising edge
  task automatic wr(int a, logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = a[3:0]; wr_data_i = d;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
    if (a < 10) m_pend[a] = d;
  endtask

  task automatic frame();
    frame_start_i = 1'b1;
    @(posedge clk_i); #1;
    frame_start_i = 1'b0;
    for (int k = 0; k < 10; k++) m_act[k] = m_pend[k];
  endtask

  task automatic send(logic [PIXW-1:0] px, string tag);
    bit taken;
    taken = 1'b0;
    in_valid_i = 1'b1; in_pix_i = px;
    exp_q.push_back(model(px)); tag_q.push_back(tag);
    while (!taken) begin
      @(negedge clk_i);
      taken = in_ready_o;
      @(posedge clk_i); #1;
    end
    in_valid_i = 1'b0;
  endtask

  task automatic drain();
    int k;
    k = 0;
    while (exp_q.size() != 0 && k < 60) begin
      @(posedge clk_i); #1; k++;
    end
    chk(exp_q.size() == 0, "R8", "pixels left undelivered", exp_q.size(), 0);
  endtask

  // in-order output comparison and stall check
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (out_valid_o && out_ready_i) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8", "pixel with none expected", out_pix_o, 0);
        end else begin
          logic [PIXW-1:0] e;
          string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          chk(out_pix_o == e, t, "output pixel", out_pix_o, e);
        end
      end
      if (out_valid_o && !out_ready_i)
        chk(!in_ready_o, "R8", "in_ready during stall", in_ready_o, 0);
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 50000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic t_reset();
    @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R1", "out_valid in reset", out_valid_o, 0);
    chk(in_ready_o == 1'b1, "R1", "in_ready in reset", in_ready_o, 1);
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R1", "out_valid after reset", out_valid_o, 0);
    @(posedge clk_i); #1;
  endtask

  task automatic t_bypass();
    out_ready_i = 1'b1;
    send(rgb(1, 2, 3), "R4");
    send(rgb(1023, 0, 1023), "R4");
    send(rgb(512, 77, 900), "R4");
    drain();
  endtask

  task automatic t_defaults();
    wr(0, 32'd1);
    frame();
    send(rgb(0, 0, 0), "R1");
    send(rgb(1023, 1023, 1023), "R1");
    send(rgb(1023, 0, 0), "R5");
    send(rgb(0, 1023, 0), "R5");
    send(rgb(300, 600, 900), "R5");
    drain();
  endtask

  task automatic t_shadow();
    wr(3, pk13(1024, 0));
    send(rgb(400, 200, 100), "R3");
    drain();
    frame();
    send(rgb(400, 200, 100), "R3");
    drain();
  endtask

  task automatic t_bad_addr();
    wr(10, 32'd0);
    wr(15, 32'hFFFF_FFFF);
    frame();
    send(rgb(250, 500, 750), "R2");
    drain();
  endtask

  task automatic t_offset_shift();
    wr(3, pk13(1024, 0)); wr(4, pk13(0, 0));
    wr(5, pk13(1024, 0)); wr(6, pk13(0, 0));
    wr(7, (32'd3 << 30) | (32'd1 << 16) | 32'd1024);
    wr(1, pk12(-100, 20)); wr(2, pk12(0, 0));
    wr(8, pk12(10, 0)); wr(9, pk12(0, 0));
    frame();
    send(rgb(500, 300, 7), "R10");
    send(rgb(50, 0, 1), "R9");
    send(rgb(99, 1023, 1023), "R9");
    drain();
  endtask

  task automatic t_latency();
    int n;
    out_ready_i = 1'b1;
    in_valid_i = 1'b1; in_pix_i = rgb(123, 456, 789);
    exp_q.push_back(model(in_pix_i)); tag_q.push_back("R7");
    @(negedge clk_i);
    chk(in_ready_o, "R7", "in_ready when empty", in_ready_o, 1);
    @(posedge clk_i); #1;
    in_valid_i = 1'b0;
    n = 0;
    do begin
      @(negedge clk_i); n++;
    end while (!out_valid_o && n < 10);
    chk(n == 3, "R7", "latency in cycles", n, 3);
    @(posedge clk_i); #1;
    drain();
  endtask

  task automatic t_backpressure();
    fork
      begin
        for (int k = 0; k < 24; k++)
          send(rgb(k * 37, k * 91 + 5, 1023 - k * 13), "R8");
      end
      begin
        for (int k = 0; k < 80; k++) begin
          out_ready_i = !((k % 3 == 0) || (k >= 30 && k < 38));
          @(posedge clk_i); #1;
        end
        out_ready_i = 1'b1;
      end
    join
    drain();
  endtask

  task automatic t_saturate();
    wr(3, pk13(4095, 4095)); wr(4, pk13(0, 0));
    wr(5, pk13(0, 0)); wr(6, pk13(-4096, 0));
    wr(7, 32'd0); wr(1, 32'd0); wr(2, 32'd0);
    wr(8, pk12(2047, 0)); wr(9, pk12(0, 0));
    frame();
    send(rgb(1023, 1023, 1023), "R6");
    send(rgb(1, 0, 0), "R6");
    drain();
  endtask

  initial begin
    init_model();
    repeat (3) @(posedge clk_i);
    t_reset();
    t_bypass();
    t_defaults();
    t_shadow();
    t_bad_addr();
    t_offset_shift();
    t_latency();
    t_backpressure();
    t_saturate();
    repeat (4) @(posedge clk_i);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule